// File: doc/BRIEF.md
# DAC Channel Update Controller

This block handles the digital side of a 32-channel DAC. Each channel has an input code, a gain word and an offset word. From these it computes a corrected code and holds that code until a load strobe copies it into the channel's output register. Write commands come in on one valid/ready command port. A single calibration engine serves all channels one at a time. Its result is held back from the outputs until the load strobe arrives.

The load strobe is the active-low `ldac_n` pin. A strobe that arrives while work is pending is remembered and carried out once the block is idle. Channels are grouped eight to a group, and a group can be set to alternate between two codes on every strobe, which produces a square wave. A clear loads every output with a programmable clear code. It can come from the `clr_n` pin or from a command. A soft reset command restores every register to its default value. The same reset sequence also runs after power-on reset. The reset, clear and compute phases each last a fixed number of clock cycles set by parameters.

Command port rules:
- A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is low only during a reset sequence. During that time the sender must hold its command until `cmd_ready` returns.
- Commands are still taken while `busy_n` is low for computation or clear.

Top module: `dac_update_ctrl`

## Requirements
- R1: `cmd_ready` is high whenever no reset sequence is running, including while a computation is pending. Command kinds are coded as follows: 0 input code, 1 gain, 2 offset, 3 clear code, 4 soft clear, 5 control, 6 soft reset, 7 no-op.
- R2: The corrected code equals floor(x1·(m+2)/16384) + c − 8192, limited to the range 0 to 16383.
- R3: Bit 0 of a gain write is stored as zero. After reset, gain is 0x3FFE and offset is 0x2000, so the corrected code equals the input code.
- R4: `busy_n` goes low in the cycle after an input, gain or offset write and stays low until the computation is done. No output changes until a load strobe is seen.
- R5: A falling edge on `ldac_n` while `busy_n` is low is stored, and the outputs update once `busy_n` returns high.
- R6: While `ldac_n` is held low, every completed computation reaches the outputs without any further edge on `ldac_n`.
- R7: On a strobe, a channel outside toggle mode is loaded only if its corrected code was recomputed since the previous strobe.
- R8: Control data bit 2+g enables toggle for group g, which covers channels 8g to 8g+7. In a toggling group, the first strobe loads the A code and each later strobe alternates between B and A. After toggle is turned off, the next strobe loads A.
- R9: An input write with `cmd_sel_b` high is dropped unless the channel's group has toggle enabled.
- R10: A falling edge on `clr_n`, or a soft clear command, loads every output with the clear code (0 after reset). `busy_n` is low in the cycles that follow.
- R11: During a reset sequence (after power-on reset or a soft reset command), `busy_n` and `cmd_ready` are low, all outputs are zero, and load strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; a reset sequence follows it |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_kind | input | 3 | Command kind (see R1) |
| cmd_sel_b | input | 1 | Input write targets the B code |
| cmd_chan | input | 5 | Channel index |
| cmd_data | input | 14 | Data word |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear, acts on its falling edge |
| busy_n | output | 1 | Low while computing, clearing or resetting |
| dac_codes | output | 448 | Output codes; channel k is in bits 14k+13 to 14k |

## Verification
The hardest cases to reach from the ports are the ones that depend on hidden history. These are:
- a stored strobe that must survive an unfinished computation;
- a channel that must not reload because nothing changed since the last strobe;
- a B-code write that was dropped.

The bench drives the strobe in the cycle right after a write, while `busy_n` is provably low. It uses a clear to put a known value on every output, then strobes again and checks that the outputs do not move. For the dropped write, it enables toggling afterwards and steps the group to its B phase, which exposes the B code on the output.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  typedef enum logic [2:0] {
    CK_X1      = 3'd0,
    CK_GAIN    = 3'd1,
    CK_OFFS    = 3'd2,
    CK_CLRCODE = 3'd3,
    CK_SOFTCLR = 3'd4,
    CK_CTRL    = 3'd5,
    CK_SOFTRST = 3'd6,
    CK_NOP     = 3'd7
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_RST = 2'd1,
    PH_CLR = 2'd2
  } phase_e;
endpackage

// File: rtl/dac_cal_engine.sv
module dac_cal_engine #(
  parameter int NCH      = 32,
  parameter int COMP_CYC = 4,
  localparam int CHW     = $clog2(NCH),
  localparam int KW      = $clog2(COMP_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [NCH-1:0] set_mask,
  output logic           busy,
  output logic           done,
  output logic [CHW-1:0] cur_ch
);
  logic [NCH-1:0] pend;
  logic           active;
  logic [KW-1:0]  cnt;
  logic [CHW-1:0] nxt_ch;

  // lowest pending channel goes first
  always_comb begin
    nxt_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) nxt_ch = CHW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      active <= 1'b0;
      cnt    <= '0;
      cur_ch <= '0;
    end else if (flush) begin
      pend   <= '0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      if (!active && (|pend)) begin
        active <= 1'b1;
        cur_ch <= nxt_ch;
        cnt    <= KW'(COMP_CYC - 1);
        pend   <= (pend & ~(NCH'(1) << nxt_ch)) | set_mask;
      end else begin
        pend <= pend | set_mask;
      end
      if (active) begin
        if (cnt == '0) active <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
    end
  end

  assign done = active && (cnt == '0);
  assign busy = active || (|pend);

  assert_busy_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_mask) && !flush) |=> busy);
endmodule

// File: rtl/dac_phase_ctl.sv
module dac_phase_ctl
  import dac_ctl_pkg::*;
#(
  parameter int RST_CYC = 8,
  parameter int CLR_CYC = 6,
  localparam int MAXC   = (RST_CYC > CLR_CYC) ? RST_CYC : CLR_CYC,
  localparam int CW     = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic soft_clr,
  input  logic clr_n,
  input  logic ldac_n,
  input  logic eng_busy,
  input  logic eng_done,
  output logic in_rst,
  output logic clr_go,
  output logic apply,
  output logic busy_n
);
  phase_e         state;
  logic [CW-1:0]  cnt;
  logic           clr_q, ldac_q, ldac_pend;
  logic           clr_fall, ldac_fall;

  assign clr_fall  = clr_q && !clr_n;
  assign ldac_fall = ldac_q && !ldac_n;
  assign in_rst    = (state == PH_RST);
  assign clr_go    = (clr_fall || soft_clr) && !in_rst && !soft_rst;
  assign busy_n    = (state == PH_RUN) && !eng_busy;
  assign apply     = ldac_pend && busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PH_RST;
      cnt       <= CW'(RST_CYC - 1);
      clr_q     <= 1'b1;
      ldac_q    <= 1'b1;
      ldac_pend <= 1'b0;
    end else begin
      clr_q  <= clr_n;
      ldac_q <= ldac_n;
      if (soft_rst) begin
        state <= PH_RST;
        cnt   <= CW'(RST_CYC - 1);
      end else if (clr_go) begin
        state <= PH_CLR;
        cnt   <= CW'(CLR_CYC - 1);
      end else if (state != PH_RUN) begin
        if (cnt == '0) state <= PH_RUN;
        else           cnt   <= cnt - 1'b1;
      end
      if (in_rst || soft_rst) ldac_pend <= 1'b0;
      else ldac_pend <= (ldac_pend && !apply) || ldac_fall || (eng_done && !ldac_n);
    end
  end

  assert_ldac_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_pend && !busy_n && !in_rst && !soft_rst) |=> ldac_pend);
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_ctl_pkg::*;
#(
  parameter int NCH     = 32,
  parameter int W       = 14,
  parameter int GRP     = 8,
  parameter int TGL_LSB = 2,
  localparam int CHW    = $clog2(NCH),
  localparam int NGRP   = NCH / GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_rst,
  input  logic             wr_en,
  input  cmd_kind_e        wr_kind,
  input  logic             wr_b,
  input  logic [CHW-1:0]   wr_ch,
  input  logic [W-1:0]     wr_data,
  input  logic             done,
  input  logic [CHW-1:0]   done_ch,
  input  logic             clr_go,
  input  logic             apply,
  output logic [NCH-1:0]   set_mask,
  output logic [NCH*W-1:0] dac_flat
);
  localparam logic [W-1:0] M_DEF = {{(W-1){1'b1}}, 1'b0};
  localparam logic [W-1:0] C_DEF = {1'b1, {(W-1){1'b0}}};
  localparam int           C_MID = 1 << (W - 1);
  localparam int           V_MAX = (1 << W) - 1;

  logic [W-1:0]    x1a [NCH];
  logic [W-1:0]    x1b [NCH];
  logic [W-1:0]    gm  [NCH];
  logic [W-1:0]    oc  [NCH];
  logic [W-1:0]    x2a [NCH];
  logic [W-1:0]    x2b [NCH];
  logic [W-1:0]    dac [NCH];
  logic [NCH-1:0]  dirty;
  logic [W-1:0]    clrcode;
  logic [NGRP-1:0] tgl_en, nxtb;
  logic            b_ok;

  function automatic logic [W-1:0] corr(input logic [W-1:0] x1, input logic [W-1:0] m,
                                        input logic [W-1:0] c);
    logic [2*W:0] prod;
    int           t;
    prod = {{(W+1){1'b0}}, x1} * {{W{1'b0}}, ({1'b0, m} + (W+1)'(2))};
    t    = int'(prod[2*W-1:W]) + int'(c) - C_MID;
    if (t < 0)          return '0;
    else if (t > V_MAX) return V_MAX[W-1:0];
    else                return t[W-1:0];
  endfunction

  assign b_ok = tgl_en[int'(wr_ch) / GRP];

  always_comb begin
    set_mask = '0;
    if (wr_en && ((wr_kind == CK_X1 && (!wr_b || b_ok)) ||
                  wr_kind == CK_GAIN || wr_kind == CK_OFFS))
      set_mask[wr_ch] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || in_rst) begin
      for (int i = 0; i < NCH; i++) begin
        x1a[i] <= '0;
        x1b[i] <= '0;
        gm[i]  <= M_DEF;
        oc[i]  <= C_DEF;
        x2a[i] <= '0;
        x2b[i] <= '0;
        dac[i] <= '0;
      end
      dirty   <= '0;
      clrcode <= '0;
      tgl_en  <= '0;
      nxtb    <= '0;
    end else begin
      if (apply) begin
        for (int i = 0; i < NCH; i++) begin
          if (tgl_en[i / GRP])  dac[i] <= nxtb[i / GRP] ? x2b[i] : x2a[i];
          else if (dirty[i])    dac[i] <= x2a[i];
        end
        dirty <= '0;
        nxtb  <= nxtb ^ tgl_en;
      end
      if (wr_en) begin
        case (wr_kind)
          CK_X1: begin
            if (!wr_b)     x1a[wr_ch] <= wr_data;
            else if (b_ok) x1b[wr_ch] <= wr_data;
          end
          CK_GAIN:    gm[wr_ch] <= {wr_data[W-1:1], 1'b0};
          CK_OFFS:    oc[wr_ch] <= wr_data;
          CK_CLRCODE: clrcode   <= wr_data;
          CK_CTRL: begin
            for (int g = 0; g < NGRP; g++) begin
              tgl_en[g] <= wr_data[TGL_LSB + g];
              if (!wr_data[TGL_LSB + g]) begin
                nxtb[g] <= 1'b0;
                // a group leaving toggle reloads its A code on the next strobe
                if (tgl_en[g]) begin
                  for (int k = 0; k < GRP; k++) dirty[g*GRP + k] <= 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
      if (done) begin
        x2a[done_ch]   <= corr(x1a[done_ch], gm[done_ch], oc[done_ch]);
        x2b[done_ch]   <= corr(x1b[done_ch], gm[done_ch], oc[done_ch]);
        dirty[done_ch] <= 1'b1;
      end
      if (clr_go) begin
        for (int i = 0; i < NCH; i++) dac[i] <= clrcode;
      end
    end
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_out
    assign dac_flat[gi*W +: W] = dac[gi];
  end

  assert_clear_loads_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_go && !in_rst) |=> (dac[NCH-1] == $past(clrcode)));

  assert_clean_channel_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !clr_go && !in_rst && !tgl_en[0] && !dirty[0]) |=> $stable(dac[0]));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_ctl_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int W        = 14,
  parameter int GRP      = 8,
  parameter int TGL_LSB  = 2,
  parameter int COMP_CYC = 4,
  parameter int CLR_CYC  = 6,
  parameter int RST_CYC  = 8,
  localparam int CHW     = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_kind,
  input  logic             cmd_sel_b,
  input  logic [CHW-1:0]   cmd_chan,
  input  logic [W-1:0]     cmd_data,
  input  logic             ldac_n,
  input  logic             clr_n,
  output logic             busy_n,
  output logic [NCH*W-1:0] dac_codes
);
  cmd_kind_e      kind;
  logic           acc, in_rst, clr_go, apply;
  logic           eng_busy, eng_done;
  logic [CHW-1:0] eng_ch;
  logic [NCH-1:0] set_mask;

  assign kind      = cmd_kind_e'(cmd_kind);
  assign cmd_ready = !in_rst;
  assign acc       = cmd_valid && cmd_ready;

  dac_phase_ctl #(.RST_CYC(RST_CYC), .CLR_CYC(CLR_CYC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (acc && kind == CK_SOFTRST),
    .soft_clr (acc && kind == CK_SOFTCLR),
    .clr_n    (clr_n),
    .ldac_n   (ldac_n),
    .eng_busy (eng_busy),
    .eng_done (eng_done),
    .in_rst   (in_rst),
    .clr_go   (clr_go),
    .apply    (apply),
    .busy_n   (busy_n)
  );

  dac_cal_engine #(.NCH(NCH), .COMP_CYC(COMP_CYC)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (in_rst),
    .set_mask (set_mask),
    .busy     (eng_busy),
    .done     (eng_done),
    .cur_ch   (eng_ch)
  );

  dac_chan_bank #(.NCH(NCH), .W(W), .GRP(GRP), .TGL_LSB(TGL_LSB)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_rst   (in_rst),
    .wr_en    (acc),
    .wr_kind  (kind),
    .wr_b     (cmd_sel_b),
    .wr_ch    (cmd_chan),
    .wr_data  (cmd_data),
    .done     (eng_done),
    .done_ch  (eng_ch),
    .clr_go   (clr_go),
    .apply    (apply),
    .set_mask (set_mask),
    .dac_flat (dac_codes)
  );

  assert_outputs_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !in_rst && !clr_go) |=> $stable(dac_codes));

  assert_reset_zeroes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rst && $past(in_rst)) |-> (dac_codes == '0));
endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;
  localparam int NCH = 32;
  localparam int W   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [2:0]       cmd_kind  = 3'd7;
  logic             cmd_sel_b = 1'b0;
  logic [4:0]       cmd_chan  = '0;
  logic [W-1:0]     cmd_data  = '0;
  logic             ldac_n    = 1'b1;
  logic             clr_n     = 1'b1;
  logic             busy_n;
  logic [NCH*W-1:0] dac_codes;

  int n_chk  = 0;
  int n_fail = 0;

  dac_update_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_sel_b(cmd_sel_b), .cmd_chan(cmd_chan),
    .cmd_data(cmd_data), .ldac_n(ldac_n), .clr_n(clr_n), .busy_n(busy_n),
    .dac_codes(dac_codes)
  );

  // {x1, gain, offset, expected}
  localparam logic [4*W-1:0] VEC [6] = '{
    {14'd1000,  14'h3FFE, 14'h2000, 14'd1000},
    {14'd16383, 14'h0001, 14'h2000, 14'd1},
    {14'd1000,  14'h3FFE, 14'h2100, 14'd1256},
    {14'd16383, 14'h3FFE, 14'h3FFF, 14'd16383},
    {14'd100,   14'h3FFE, 14'h0000, 14'd0},
    {14'd8192,  14'h1FFE, 14'h2000, 14'd4096}
  };

  function automatic int chv(int ch);
    return int'(dac_codes[ch*W +: W]);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(int kind, bit sel_b, int ch, int data);
    @(negedge clk);
    cmd_kind  = 3'(kind);
    cmd_sel_b = sel_b;
    cmd_chan  = 5'(ch);
    cmd_data  = W'(data);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_sel_b = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!busy_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) ldac_n = 1'b0;
    @(negedge clk) ldac_n = 1'b1;
    wait_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: power-on reset sequence
    chk("R11", "busy_n in reset", int'(busy_n), 0);
    chk("R11", "cmd_ready in reset", int'(cmd_ready), 0);
    wait_idle();
    chk("R11", "busy_n after reset", int'(busy_n), 1);
    chk("R1", "cmd_ready after reset", int'(cmd_ready), 1);
    begin
      int nz = 0;
      for (int i = 0; i < NCH; i++) if (chv(i) != 0) nz++;
      chk("R11", "nonzero outputs after reset", nz, 0);
    end

    // R2/R3: table of calibration cases
    for (int i = 0; i < 6; i++) begin
      int ch = i * 5;
      send(1, 1'b0, ch, int'(VEC[i][2*W +: W]));
      send(2, 1'b0, ch, int'(VEC[i][W +: W]));
      send(0, 1'b0, ch, int'(VEC[i][3*W +: W]));
      wait_idle();
      strobe();
      chk(i == 1 ? "R3" : "R2", $sformatf("vector %0d", i), chv(ch), int'(VEC[i][0 +: W]));
    end

    // R4: busy after write, output held without strobe
    send(0, 1'b0, 12, 2222);
    chk("R4", "busy_n after write", int'(busy_n), 0);
    wait_idle();
    chk("R4", "ch12 before strobe", chv(12), 0);
    strobe();
    chk("R4", "ch12 after strobe", chv(12), 2222);

    // R5: strobe during busy is stored
    send(0, 1'b0, 13, 3333);
    ldac_n = 1'b0;
    @(negedge clk) ldac_n = 1'b1;
    chk("R5", "busy_n at strobe", int'(busy_n), 0);
    chk("R5", "ch13 while busy", chv(13), 0);
    wait_idle();
    chk("R5", "ch13 after busy", chv(13), 3333);

    // R6: strobe held low
    @(negedge clk) ldac_n = 1'b0;
    send(0, 1'b0, 14, 444);
    wait_idle();
    chk("R6", "ch14 first", chv(14), 444);
    send(0, 1'b0, 14, 555);
    wait_idle();
    chk("R6", "ch14 second", chv(14), 555);
    @(negedge clk) ldac_n = 1'b1;

    // R1: commands taken while busy
    send(0, 1'b0, 16, 1600);
    chk("R1", "cmd_ready while busy", int'(cmd_ready && !busy_n), 1);
    send(0, 1'b0, 17, 1700);
    wait_idle();
    strobe();
    chk("R1", "ch16", chv(16), 1600);
    chk("R1", "ch17", chv(17), 1700);

    // R10 soft clear, then R7 no reload of unchanged channels
    send(3, 1'b0, 0, 77);
    send(4, 1'b0, 0, 0);
    chk("R10", "busy_n after soft clear", int'(busy_n), 0);
    chk("R10", "ch0 clear code", chv(0), 77);
    chk("R10", "ch31 clear code", chv(31), 77);
    wait_idle();
    strobe();
    chk("R7", "ch5 unchanged after strobe", chv(5), 77);
    send(0, 1'b0, 5, 600);
    wait_idle();
    strobe();
    chk("R7", "ch5 rewritten", chv(5), 600);
    chk("R7", "ch6 untouched", chv(6), 77);

    // R10 clear pin
    send(3, 1'b0, 0, 123);
    @(negedge clk) clr_n = 1'b0;
    @(negedge clk) clr_n = 1'b1;
    chk("R10", "busy_n after clr pin", int'(busy_n), 0);
    chk("R10", "ch31 after clr pin", chv(31), 123);
    wait_idle();

    // R8 toggle group 0
    send(5, 1'b0, 0, 14'h0004);
    send(0, 1'b0, 3, 300);
    send(0, 1'b1, 3, 700);
    wait_idle();
    strobe(); chk("R8", "toggle 1st A", chv(3), 300);
    strobe(); chk("R8", "toggle 2nd B", chv(3), 700);
    strobe(); chk("R8", "toggle 3rd A", chv(3), 300);
    strobe(); chk("R8", "toggle 4th B", chv(3), 700);
    send(5, 1'b0, 0, 0);
    strobe(); chk("R8", "after disable A", chv(3), 300);

    // R9 B write dropped while group off
    send(0, 1'b1, 9, 900);
    send(5, 1'b0, 0, 14'h0008);
    send(0, 1'b0, 9, 50);
    wait_idle();
    strobe(); chk("R9", "ch9 A", chv(9), 50);
    strobe(); chk("R9", "ch9 B kept default", chv(9), 0);

    // R11 soft reset restores defaults
    send(6, 1'b0, 0, 0);
    chk("R11", "busy_n in soft reset", int'(busy_n), 0);
    chk("R11", "cmd_ready in soft reset", int'(cmd_ready), 0);
    @(negedge clk) ldac_n = 1'b0;
    @(negedge clk) ldac_n = 1'b1;
    chk("R11", "ch31 zero in reset", chv(31), 0);
    wait_idle();
    chk("R11", "ch9 zero after reset", chv(9), 0);
    send(0, 1'b0, 25, 1000);
    wait_idle();
    chk("R11", "ch25 no strobe yet", chv(25), 0);
    strobe();
    chk("R3", "ch25 default gain/offset", chv(25), 1000);

    summary();
    $finish;
  end
endmodule